// File: doc/BRIEF.md
# Seconds-Count Real-Time Clock with Alarm

This block keeps wall time as a single 32-bit count of seconds. A prescaler divides the bus clock down to one tick per second. Each tick advances the count and raises a sticky tick flag. A 32-bit alarm word is compared against the count on every tick. When they meet and the alarm is armed, a second sticky flag is raised. The two flags, each gated by its own enable, are merged into one level interrupt.

Software reaches the block through a simple bus-clock register port with an address, a write strobe, write data and combinational read data. The port gives access to a control/status word, the seconds count, the alarm word, a general regulator word and a scratchpad.

Every accepted write makes the block busy for a fixed number of cycles, which models the slow update of a low-power domain. Writes that arrive while the block is busy are dropped, so software polls the ready bit before it writes. The scratchpad keeps its value through a bus reset. Software can therefore store a marker there and recognise a first power-up.

Top module: `secrtc`

## Requirements
- R1: After reset, the control word reads 0x00000080 (only the ready bit set). The seconds, alarm and regulator words read zero, and the interrupt output is low.
- R2: While control bit 0 (run) is 1, a tick occurs once every DIV clock cycles. Each tick adds one to the seconds count and sets control bit 6 (tick flag). While run is 0, the count holds its value.
- R3: Control bit 7 (ready) reads 0 for exactly BUSY cycles after an accepted write. A write presented while ready is 0 is dropped and changes no register.
- R4: A control write with 0 in bit 6 or bit 4 (alarm flag) clears that flag. A control write with 1 in that bit leaves the flag as it was. When an event and a clearing write fall in the same cycle, the event wins.
- R5: A tick that brings the seconds count equal to the alarm word sets the alarm flag, but only when control bit 2 (alarm arm) is 1. A tick in the same cycle as a seconds write never raises the alarm flag.
- R6: The irq output is high exactly when the tick flag is set together with control bit 5 (tick interrupt enable), or when the alarm flag is set together with control bit 3 (alarm interrupt enable).
- R7: Writing offset 0x04 loads the seconds count, and the loaded value takes precedence over a tick in the same cycle. The count wraps from 0xFFFFFFFF to 0.
- R8: The scratchpad at offset 0x34 is a 32-bit read/write word that keeps its value across reset.
- R9: The words sit at these offsets: control 0x00, seconds 0x04, alarm 0x08, regulator 0x0C, scratchpad 0x34. Reads of any other offset return zero, and writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with DIV=64 and BUSY=3. With these values a second lasts only 64 cycles, so a wrap from 0xFFFFFFFF, alarm hits, and repeated flag set/clear sequences all fit in a few thousand cycles. A busy window of three cycles leaves room to land a dropped write inside it and to count the exact length of the window. A behavioural model steps alongside the design and compares the read data and irq on every cycle. Directed checks then target wrap-around, armed versus unarmed alarms, and the effect of writing 1 versus 0 to a flag.

// File: rtl/secrtc_pkg.sv
package secrtc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_SEC     = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_ALARM   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_REGUL   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_SCRATCH = 8'h34;

  localparam int B_RUN  = 0;
  localparam int B_ARM  = 2;
  localparam int B_AIE  = 3;
  localparam int B_AFL  = 4;
  localparam int B_TIE  = 5;
  localparam int B_TFL  = 6;
  localparam int B_RDY  = 7;

  typedef struct packed {
    logic tick_fl;
    logic tick_ie;
    logic alm_fl;
    logic alm_ie;
    logic arm;
    logic run;
  } ctl_t;

  // Pack the control state and ready bit into a bus word.
  function automatic logic [DATA_W-1:0] ctl_word(ctl_t c, logic rdy);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_RUN] = c.run;
    w[B_ARM] = c.arm;
    w[B_AIE] = c.alm_ie;
    w[B_AFL] = c.alm_fl;
    w[B_TIE] = c.tick_ie;
    w[B_TFL] = c.tick_fl;
    w[B_RDY] = rdy;
    return w;
  endfunction

  // Sticky flag: cleared only by a write carrying 0, set by an event (event wins).
  function automatic logic flag_next(logic cur, logic wr, logic wbit, logic set);
    return (cur & ~(wr & ~wbit)) | set;
  endfunction

  function automatic logic [DATA_W-1:0] sec_inc(logic [DATA_W-1:0] s);
    return s + {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/secrtc_prescale.sv
module secrtc_prescale #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  // R2
  prescale_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/secrtc_wrgate.sv
module secrtc_wrgate #(
  parameter int BUSY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  output logic accept,
  output logic ready
);
  localparam int BW = $clog2(BUSY + 1);
  localparam logic [BW-1:0] LOAD = BW'(BUSY);

  logic [BW-1:0] cnt_q;

  assign ready  = (cnt_q == '0);
  assign accept = wr_req && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (accept) cnt_q <= LOAD;
    else if (!ready) cnt_q <= cnt_q - 1'b1;
  end

  // R3
  busy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);
endmodule

// File: rtl/secrtc_alarm_cmp.sv
module secrtc_alarm_cmp
  import secrtc_pkg::*;
(
  input  logic              tick,
  input  logic              arm,
  input  logic              sec_load,
  input  logic [DATA_W-1:0] sec_now,
  input  logic [DATA_W-1:0] alarm,
  output logic              hit
);
  assign hit = tick && arm && !sec_load && (sec_inc(sec_now) == alarm);
endmodule

// File: rtl/secrtc.sv
module secrtc
  import secrtc_pkg::*;
#(
  parameter int DIV  = 32768,
  parameter int BUSY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  ctl_t              ctl_q;
  logic [DATA_W-1:0] sec_q, alarm_q, regul_q;
  logic [DATA_W-1:0] scratch_q = '0;

  logic accept, wr_ready, tick, alarm_hit;
  logic wr_ctrl, wr_sec, wr_alarm, wr_regul, wr_scratch;

  secrtc_wrgate #(.BUSY(BUSY)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_en), .accept(accept), .ready(wr_ready));

  secrtc_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctl_q.run), .tick(tick));

  secrtc_alarm_cmp u_cmp (
    .tick(tick), .arm(ctl_q.arm), .sec_load(wr_sec), .sec_now(sec_q),
    .alarm(alarm_q), .hit(alarm_hit));

  assign wr_ctrl    = accept && (addr == OFF_CTRL);
  assign wr_sec     = accept && (addr == OFF_SEC);
  assign wr_alarm   = accept && (addr == OFF_ALARM);
  assign wr_regul   = accept && (addr == OFF_REGUL);
  assign wr_scratch = accept && (addr == OFF_SCRATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      ctl_q.tick_fl <= flag_next(ctl_q.tick_fl, wr_ctrl, wdata[B_TFL], tick);
      ctl_q.alm_fl  <= flag_next(ctl_q.alm_fl,  wr_ctrl, wdata[B_AFL], alarm_hit);
      if (wr_ctrl) begin
        ctl_q.run     <= wdata[B_RUN];
        ctl_q.arm     <= wdata[B_ARM];
        ctl_q.alm_ie  <= wdata[B_AIE];
        ctl_q.tick_ie <= wdata[B_TIE];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sec_q <= '0;
    else if (wr_sec) sec_q <= wdata;
    else if (tick)   sec_q <= sec_inc(sec_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
      regul_q <= '0;
    end else begin
      if (wr_alarm) alarm_q <= wdata;
      if (wr_regul) regul_q <= wdata;
    end
  end

  // Scratchpad has no reset: it survives bus resets.
  always_ff @(posedge clk) begin
    if (wr_scratch) scratch_q <= wdata;
  end

  assign irq = (ctl_q.tick_fl && ctl_q.tick_ie) || (ctl_q.alm_fl && ctl_q.alm_ie);

  always_comb begin
    case (addr)
      OFF_CTRL:    rdata = ctl_word(ctl_q, wr_ready);
      OFF_SEC:     rdata = sec_q;
      OFF_ALARM:   rdata = alarm_q;
      OFF_REGUL:   rdata = regul_q;
      OFF_SCRATCH: rdata = scratch_q;
      default:     rdata = '0;
    endcase
  end

  // R7
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_sec) |=> (sec_q == $past(sec_q) + 32'd1));

  // R2
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.run && !wr_sec) |=> $stable(sec_q));

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.tick_fl && !(wr_ctrl && !wdata[B_TFL])) |=> ctl_q.tick_fl);

  // R5
  alarm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> ctl_q.alm_fl);

  // R3
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ready) |=> ($stable(alarm_q) && $stable(regul_q) && $stable(scratch_q)));

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctl_q.tick_fl || ctl_q.alm_fl));
endmodule

// File: tb/sim_secrtc.sv
module sim_secrtc;
  localparam int DIV  = 64;
  localparam int BUSY = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  secrtc #(.DIV(DIV), .BUSY(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  // Behavioural reference model
  logic [31:0] msec = 0, malarm = 0, mreg = 0, mscr = 0;
  bit men, marm, maie, mafl, mtie, mtfl;
  int mpre = 0, mbusy = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msec = 0; malarm = 0; mreg = 0;
      men = 0; marm = 0; maie = 0; mafl = 0; mtie = 0; mtfl = 0;
      mpre = 0; mbusy = 0;
    end else begin
      bit acc, tk, hit, wc;
      acc = wr_en && (mbusy == 0);
      tk  = men && (mpre == DIV - 1);
      hit = tk && marm && !(acc && addr == 8'h04) && ((msec + 32'd1) == malarm);
      wc  = acc && (addr == 8'h00);
      mpre  = (men && !tk) ? mpre + 1 : 0;
      mbusy = acc ? BUSY : (mbusy > 0 ? mbusy - 1 : 0);
      mtfl = ((wc && !wdata[6]) ? 1'b0 : mtfl) | tk;
      mafl = ((wc && !wdata[4]) ? 1'b0 : mafl) | hit;
      if (wc) begin
        men = wdata[0]; marm = wdata[2]; maie = wdata[3]; mtie = wdata[5];
      end
      if (acc && addr == 8'h04) msec = wdata;
      else if (tk)              msec = msec + 32'd1;
      if (acc && addr == 8'h08) malarm = wdata;
      if (acc && addr == 8'h0C) mreg = wdata;
      if (acc && addr == 8'h34) mscr = wdata;
    end
  end

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      8'h00: return {24'd0, (mbusy == 0), mtfl, mtie, mafl, maie, marm, 1'b0, men};
      8'h04: return msec;
      8'h08: return malarm;
      8'h0C: return mreg;
      8'h34: return mscr;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison just before each rising edge
  always @(negedge clk) begin
    #9;
    if (rst_n) begin
      chk(addr == 8'h00 ? "R3 model ctrl" : "R9 model read", rdata, model_read(addr));
      chk("R6 model irq", {31'd0, irq}, {31'd0, (mtfl && mtie) || (mafl && maie)});
    end
  end

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    addr = a; wr_en = 1'b0; #1; v = rdata;
  endtask

  task automatic wait_ready();
    logic [31:0] v;
    rd(8'h00, v);
    while (!v[7]) begin
      @(negedge clk); rd(8'h00, v);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    wait_ready();
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'h00;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_all();
    logic [31:0] v, s, prev;
    int n;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, v); chk("R1 ctrl after reset", v, 32'h80);
    rd(8'h04, v); chk("R1 seconds after reset", v, 0);
    rd(8'h08, v); chk("R1 alarm after reset", v, 0);
    rd(8'h0C, v); chk("R1 regulator after reset", v, 0);
    chk("R1 irq after reset", {31'd0, irq}, 0);
    // R8 scratchpad
    bus_wr(8'h34, 32'h12345678);
    wait_ready();
    rd(8'h34, v); chk("R8 scratchpad readback", v, 32'h12345678);
    // R9 unmapped
    bus_wr(8'h10, 32'hDEADBEEF);
    wait_ready();
    rd(8'h10, v); chk("R9 unmapped 0x10 reads zero", v, 0);
    rd(8'h30, v); chk("R9 unmapped 0x30 reads zero", v, 0);
    rd(8'h34, v); chk("R9 scratchpad untouched by unmapped write", v, 32'h12345678);
    // R3 busy window and dropped write
    bus_wr(8'h0C, 32'hA5);
    rd(8'h00, v); chk("R3 ready low after write", {31'd0, v[7]}, 0);
    addr = 8'h0C; wdata = 32'h5A; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    wait_ready();
    rd(8'h0C, v); chk("R3 write while busy dropped", v, 32'hA5);
    bus_wr(8'h08, 32'h77);
    n = 0; rd(8'h00, v);
    while (!v[7]) begin n++; @(negedge clk); rd(8'h00, v); end
    chk("R3 busy window length", n, BUSY);
    // R7 load and wrap, R2 tick rate
    bus_wr(8'h04, 32'hFFFFFFFE);
    bus_wr(8'h00, 32'h21);
    wait_ready();
    rd(8'h04, v); chk("R7 seconds load", v, 32'hFFFFFFFE);
    prev = v;
    while (v == prev) begin @(negedge clk); rd(8'h04, v); end
    chk("R7 first increment", v, 32'hFFFFFFFF);
    prev = v; n = 0;
    while (v == prev) begin n++; @(negedge clk); rd(8'h04, v); end
    chk("R7 wrap to zero", v, 0);
    chk("R2 tick period", n, DIV);
    rd(8'h00, v); chk("R2 tick flag set", {31'd0, v[6]}, 1);
    chk("R6 irq from tick", {31'd0, irq}, 1);
    // R4 write 1 keeps, write 0 clears
    bus_wr(8'h00, 32'h61);
    wait_ready();
    rd(8'h00, v); chk("R4 write one keeps tick flag", {31'd0, v[6]}, 1);
    bus_wr(8'h00, 32'h41);
    wait_ready();
    chk("R6 irq off with enable cleared", {31'd0, irq}, 0);
    bus_wr(8'h00, 32'h21);
    wait_ready();
    rd(8'h00, v); chk("R4 write zero clears tick flag", {31'd0, v[6]}, 0);
    chk("R6 irq low after clear", {31'd0, irq}, 0);
    // R5 unarmed alarm
    bus_wr(8'h00, 32'h01);
    rd(8'h04, s);
    bus_wr(8'h08, s + 32'd2);
    repeat (4 * DIV) @(negedge clk);
    rd(8'h00, v); chk("R5 unarmed alarm no flag", {31'd0, v[4]}, 0);
    // R5 armed alarm
    rd(8'h04, s);
    bus_wr(8'h08, s + 32'd2);
    bus_wr(8'h00, 32'h0D);
    rd(8'h00, v);
    while (!v[4]) begin @(negedge clk); rd(8'h00, v); end
    rd(8'h04, v); chk("R5 alarm at match", v, s + 32'd2);
    chk("R6 irq from alarm", {31'd0, irq}, 1);
    bus_wr(8'h00, 32'h0D);
    wait_ready();
    rd(8'h00, v); chk("R4 alarm flag cleared by zero", {31'd0, v[4]}, 0);
    // R2 hold while stopped
    bus_wr(8'h00, 32'h00);
    rd(8'h04, s);
    repeat (3 * DIV) @(negedge clk);
    rd(8'h04, v); chk("R2 count holds when stopped", v, s);
    // R8 survives reset
    do_reset();
    rd(8'h34, v); chk("R8 scratchpad survives reset", v, 32'h12345678);
    rd(8'h00, v); chk("R1 ctrl after second reset", v, 32'h80);
    rd(8'h04, v); chk("R1 seconds after second reset", v, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R3 watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule